// File: doc/BRIEF.md
# Configurable GPIO Port With Mode Bits

This block is a memory-mapped general-purpose I/O port of parameterized width (eight pins by default). A processor writes two registers over a simple byte-wide data-memory bus: a configuration register and a data register. Each pin is set up by its configuration bit together with its data bit. A third address returns the pin levels, sampled by one register stage.

Some bit positions are reserved. On the full variant, pin positions 7 and 6 carry no general I/O. A 1 written to data bit 7 sends a one-cycle HALT request pulse, and a 1 written to data bit 6 sends a one-cycle IDLE request pulse. Those two data bits are not stored and read as zero. Configuration bit 6 selects the alternate shift-clock phase and configuration bit 7 enables a clock start-up delay after HALT, both as level outputs. Pin position 1 is kept off the pads because it is the dedicated watchdog error output, but its register bits are stored. A narrow variant, chosen by parameter, turns the low four positions into plain flag storage. On that variant the low four bits of the pin read always return 1 and the mode bits are ordinary I/O.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset the data and configuration registers are zero, so every pad has output enable 0, output value 0 and pull-up 0. Both mode strobes are 0.
- R2: For a general I/O pin, the pair (configuration, data) selects the pad mode. 00 is high-impedance input, 01 is input with weak pull-up (pad_pu=1), 10 drives 0 (pad_oe=1, pad_out=0) and 11 drives 1 (pad_oe=1, pad_out=1). pad_out is 0 whenever pad_oe is 0, and pad_oe and pad_pu are never both 1.
- R3: A write to the data address with bit 7 set makes halt_req 1 for exactly the one cycle after the write edge. A write with bit 6 set does the same on idle_req. A write with the bit clear, or any write to the configuration address, makes no pulse.
- R4: On the full variant, data bits 7 and 6 always read back 0, and pins 7 and 6 are never driven or pulled.
- R5: Configuration bit 6 drives alt_clk_phase and configuration bit 7 drives startup_dly_en. Both bits read back as written.
- R6: On the full variant, pin 1 is never driven or pulled whatever the registers hold. Its configuration and data bits still read back as written.
- R7: A read is registered. bus_rdata takes the selected value at the clock edge where bus_rd is 1 and holds it until the next read. The pin address returns pad_in as sampled at the previous clock edge.
- R8: On the narrow variant, bits 3..0 of a pin read are always 1. Bits 3..0 of both registers are stored and read back but never reach the pads. Bits 7 and 6 are ordinary I/O and produce no mode strobes.
- R9: A write to an address other than data (0xD4), configuration (0xD5) or pin (0xD6) changes nothing. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Data-memory address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| halt_req | output | 1 | One-cycle HALT request |
| idle_req | output | 1 | One-cycle IDLE request |
| alt_clk_phase | output | 1 | Alternate shift-clock phase select |
| startup_dly_en | output | 1 | Start-up delay enable after HALT |

## Verification
A wrong register bit shows on the pad outputs in the cycle after the write. Its read-back appears one cycle after a read strobe. A reserved bit that is stored by mistake shows as a nonzero read of data bits 7:6, or as an enable on pins 7, 6 or 1, in the first cycle after it is written. A strobe fault shows as a pulse that is missing, lasts two cycles, or follows a configuration write. The narrow variant runs alongside the full one, so a leak of variant logic appears as a difference between the two at the same ports.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CFG  = 2'd2,
      SEL_PIN  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic oe;
      logic out;
      logic pu;
   } pad_drive_t;

   // configuration bit picks direction, data bit picks level or pull-up
   function automatic pad_drive_t pin_drive(input logic cfg_b, input logic dat_b);
      pad_drive_t d;
      d.oe  = cfg_b;
      d.out = cfg_b & dat_b;
      d.pu  = ~cfg_b & dat_b;
      return d;
   endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_port_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 'hD4,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 'hD5,
   parameter logic [ADDR_W-1:0] PIN_ADDR  = 'hD6
)(
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   if (DATA_ADDR == CFG_ADDR || DATA_ADDR == PIN_ADDR || CFG_ADDR == PIN_ADDR) begin : g_bad_map
      $error("gpio_addr_dec: register addresses must be distinct");
   end

   always_comb begin
      if (addr == DATA_ADDR)     sel = SEL_DATA;
      else if (addr == CFG_ADDR) sel = SEL_CFG;
      else if (addr == PIN_ADDR) sel = SEL_PIN;
      else                       sel = SEL_NONE;
   end

endmodule

// File: rtl/gpio_mode_regs.sv
module gpio_mode_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned PORT_W        = 8,
   parameter bit          HAS_MODE_BITS = 1'b1,
   parameter int unsigned HALT_BIT      = 7,
   parameter int unsigned IDLE_BIT      = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [PORT_W-1:0] wdata,
   output logic [PORT_W-1:0] data_q,
   output logic [PORT_W-1:0] cfg_q,
   output logic              halt_q,
   output logic              idle_q
);

   localparam logic [PORT_W-1:0] ONE       = PORT_W'(1);
   localparam logic [PORT_W-1:0] MODE_MASK = HAS_MODE_BITS ? ((ONE << HALT_BIT) | (ONE << IDLE_BIT)) : '0;

   if (HAS_MODE_BITS && (HALT_BIT >= PORT_W || IDLE_BIT >= PORT_W || HALT_BIT == IDLE_BIT)) begin : g_bad_bits
      $error("gpio_mode_regs: mode bit positions out of range or equal");
   end

   logic wr_data, wr_cfg;
   assign wr_data = wr_en && (sel == SEL_DATA);
   assign wr_cfg  = wr_en && (sel == SEL_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (wr_data) data_q <= wdata & ~MODE_MASK;
         if (wr_cfg)  cfg_q  <= wdata;
      end
   end

   if (HAS_MODE_BITS) begin : g_strobes
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            halt_q <= 1'b0;
            idle_q <= 1'b0;
         end else begin
            halt_q <= wr_data & wdata[HALT_BIT];
            idle_q <= wr_data & wdata[IDLE_BIT];
         end
      end

      assert_halt_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
         halt_q |-> $past(wr_en && sel == SEL_DATA && wdata[HALT_BIT]));
      assert_idle_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
         idle_q |-> $past(wr_en && sel == SEL_DATA && wdata[IDLE_BIT]));
      assert_cfg_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && sel == SEL_CFG) |=> (!halt_q && !idle_q));
   end else begin : g_no_strobes
      assign halt_q = 1'b0;
      assign idle_q = 1'b0;
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (data_q == '0 && cfg_q == '0 && !halt_q && !idle_q));

   assert_ignore_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE || !wr_en) |=> ($stable(data_q) && $stable(cfg_q)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpio_port_pkg::*;
#(
   parameter int unsigned PORT_W = 8,
   parameter logic [PORT_W-1:0] KEEP_OFF = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] data_q,
   input  logic [PORT_W-1:0] cfg_q,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_pu
);

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      if (KEEP_OFF[i]) begin : g_off
         assign pad_oe[i]  = 1'b0;
         assign pad_out[i] = 1'b0;
         assign pad_pu[i]  = 1'b0;
      end else begin : g_io
         pad_drive_t drv;
         assign drv        = pin_drive(cfg_q[i], data_q[i]);
         assign pad_oe[i]  = drv.oe;
         assign pad_out[i] = drv.out;
         assign pad_pu[i]  = drv.pu;
      end
   end

   assert_oe_pu_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pu) == '0);
   assert_out_needs_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);
   assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | pad_pu) & KEEP_OFF) == '0);

endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
   import gpio_port_pkg::*;
#(
   parameter int unsigned PORT_W = 8,
   parameter logic [PORT_W-1:0] FORCE_ONE = '0,
   parameter logic [PORT_W-1:0] MODE_MASK = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  reg_sel_e          sel,
   input  logic [PORT_W-1:0] data_q,
   input  logic [PORT_W-1:0] cfg_q,
   input  logic [PORT_W-1:0] pad_in,
   output logic [PORT_W-1:0] rdata
);

   logic [PORT_W-1:0] pin_s;
   logic [PORT_W-1:0] pin_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_s <= '0;
      else        pin_s <= pad_in;
   end

   for (genvar i = 0; i < PORT_W; i++) begin : g_pinrd
      if (FORCE_ONE[i]) begin : g_one
         assign pin_rd[i] = 1'b1;
      end else begin : g_live
         assign pin_rd[i] = pin_s[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         case (sel)
            SEL_DATA: rdata <= data_q;
            SEL_CFG:  rdata <= cfg_q;
            SEL_PIN:  rdata <= pin_rd;
            default:  rdata <= '0;
         endcase
      end
   end

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_NONE) |=> rdata == '0);
   assert_mode_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_DATA) |=> (rdata & MODE_MASK) == '0);
   assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
   assert_flag_pins_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_PIN) |=> (rdata & FORCE_ONE) == FORCE_ONE);

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned PORT_W        = 8,
   parameter int unsigned ADDR_W        = 8,
   parameter logic [ADDR_W-1:0] DATA_ADDR = 'hD4,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 'hD5,
   parameter logic [ADDR_W-1:0] PIN_ADDR  = 'hD6,
   parameter bit          HAS_MODE_BITS = 1'b1,
   parameter int unsigned HALT_BIT      = 7,
   parameter int unsigned IDLE_BIT      = 6,
   parameter bit          WDOG_EXCL     = 1'b1,
   parameter int unsigned WDOG_BIT      = 1,
   parameter bit          LOW_FLAGS     = 1'b0,
   parameter int unsigned FLAG_W        = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [PORT_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [PORT_W-1:0] bus_rdata,
   input  logic [PORT_W-1:0] pad_in,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_pu,
   output logic              halt_req,
   output logic              idle_req,
   output logic              alt_clk_phase,
   output logic              startup_dly_en
);

   localparam logic [PORT_W-1:0] ONE       = PORT_W'(1);
   localparam logic [PORT_W-1:0] MODE_MASK = HAS_MODE_BITS ? ((ONE << HALT_BIT) | (ONE << IDLE_BIT)) : '0;
   localparam logic [PORT_W-1:0] WDOG_MASK = WDOG_EXCL ? (ONE << WDOG_BIT) : '0;
   localparam logic [PORT_W-1:0] FLAG_MASK = LOW_FLAGS ? ((ONE << FLAG_W) - ONE) : '0;
   localparam logic [PORT_W-1:0] KEEP_OFF  = MODE_MASK | WDOG_MASK | FLAG_MASK;

   if (PORT_W < 2 || (WDOG_EXCL && WDOG_BIT >= PORT_W) || (LOW_FLAGS && FLAG_W >= PORT_W)) begin : g_bad_cfg
      $error("gpio_mode_port: parameter set is inconsistent");
   end

   reg_sel_e          sel;
   logic [PORT_W-1:0] data_q;
   logic [PORT_W-1:0] cfg_q;

   gpio_addr_dec #(
      .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CFG_ADDR(CFG_ADDR), .PIN_ADDR(PIN_ADDR)
   ) dec_i (
      .addr(bus_addr), .sel(sel)
   );

   gpio_mode_regs #(
      .PORT_W(PORT_W), .HAS_MODE_BITS(HAS_MODE_BITS), .HALT_BIT(HALT_BIT), .IDLE_BIT(IDLE_BIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(sel), .wdata(bus_wdata),
      .data_q(data_q), .cfg_q(cfg_q), .halt_q(halt_req), .idle_q(idle_req)
   );

   gpio_pad_ctrl #(
      .PORT_W(PORT_W), .KEEP_OFF(KEEP_OFF)
   ) pads_i (
      .clk(clk), .rst_n(rst_n), .data_q(data_q), .cfg_q(cfg_q),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   gpio_readback #(
      .PORT_W(PORT_W), .FORCE_ONE(FLAG_MASK), .MODE_MASK(MODE_MASK)
   ) rb_i (
      .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .sel(sel), .data_q(data_q), .cfg_q(cfg_q),
      .pad_in(pad_in), .rdata(bus_rdata)
   );

   if (HAS_MODE_BITS) begin : g_mode_lvls
      assign alt_clk_phase  = cfg_q[IDLE_BIT];
      assign startup_dly_en = cfg_q[HALT_BIT];
   end else begin : g_no_mode_lvls
      assign alt_clk_phase  = 1'b0;
      assign startup_dly_en = 1'b0;
   end

   assert_mode_lvls_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_CFG && HAS_MODE_BITS) |=>
         (alt_clk_phase == $past(bus_wdata[IDLE_BIT]) && startup_dly_en == $past(bus_wdata[HALT_BIT])));

endmodule

// File: tb/gpio_mode_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mode_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic       bus_rd = 1'b0;
   logic [7:0] pad_in = 8'h00;

   logic [7:0] rdata, oe, out, pu;
   logic       halt, idle, altph, sdly;
   logic [7:0] rdata_n, oe_n, out_n, pu_n;
   logic       halt_n, idle_n, altph_n, sdly_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam logic [7:0] A_DATA = 8'hD4;
   localparam logic [7:0] A_CFG  = 8'hD5;
   localparam logic [7:0] A_PIN  = 8'hD6;
   localparam logic [7:0] OFF_FULL   = 8'hC2;  // pins 7,6,1
   localparam logic [7:0] OFF_NARROW = 8'h0F;  // flag nibble

   always #5 clk = ~clk;

   gpio_mode_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(rdata), .pad_in(pad_in), .pad_oe(oe), .pad_out(out),
      .pad_pu(pu), .halt_req(halt), .idle_req(idle), .alt_clk_phase(altph), .startup_dly_en(sdly)
   );

   gpio_mode_port #(.HAS_MODE_BITS(1'b0), .WDOG_EXCL(1'b0), .LOW_FLAGS(1'b1)) dut_n_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(rdata_n), .pad_in(pad_in), .pad_oe(oe_n), .pad_out(out_n),
      .pad_pu(pu_n), .halt_req(halt_n), .idle_req(idle_n), .alt_clk_phase(altph_n),
      .startup_dly_en(sdly_n)
   );

   task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive at falling edge, registers update at the rising edge, sample at next falling edge
   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic t_reset_state();
      check("R1", "oe", oe, 8'h00);
      check("R1", "pu", pu, 8'h00);
      check("R1", "out", out, 8'h00);
      check("R1", "strobes", {6'b0, halt, idle}, 8'h00);
      bus_read(A_CFG);
      check("R1", "cfg read", rdata, 8'h00);
   endtask

   task automatic t_encoding(input logic [7:0] c, input logic [7:0] d);
      bus_write(A_CFG, c);
      bus_write(A_DATA, d);
      check("R2", "oe", oe, c & ~OFF_FULL);
      check("R2", "out", out, c & d & ~OFF_FULL);
      check("R2", "pu", pu, ~c & d & ~OFF_FULL);
   endtask

   task automatic t_strobes();
      bus_write(A_DATA, 8'h80);
      check("R3", "halt pulse", {6'b0, halt, idle}, 8'h02);
      @(negedge clk);
      check("R3", "halt ends", {6'b0, halt, idle}, 8'h00);
      bus_write(A_DATA, 8'h40);
      check("R3", "idle pulse", {6'b0, halt, idle}, 8'h01);
      @(negedge clk);
      check("R3", "idle ends", {6'b0, halt, idle}, 8'h00);
      bus_write(A_DATA, 8'h3F);
      check("R3", "no pulse on clear bits", {6'b0, halt, idle}, 8'h00);
      bus_write(A_CFG, 8'hC0);
      check("R3", "no pulse on cfg write", {6'b0, halt, idle}, 8'h00);
      check("R8", "narrow no strobe", {6'b0, halt_n, idle_n}, 8'h00);
   endtask

   task automatic t_mode_and_wdog();
      bus_write(A_CFG, 8'hFF);
      bus_write(A_DATA, 8'hFF);
      check("R5", "mode levels", {6'b0, sdly, altph}, 8'h03);
      check("R4", "pins 7,6 quiet", (oe | pu) & 8'hC0, 8'h00);
      check("R6", "pin1 quiet", (oe | pu) & 8'h02, 8'h00);
      bus_read(A_DATA);
      check("R4", "data read masks 7,6", rdata, 8'h3F);
      check("R8", "narrow data read", rdata_n, 8'hFF);
      check("R8", "narrow flags off pads", oe_n & OFF_NARROW, 8'h00);
      check("R8", "narrow upper driven", oe_n, 8'hF0);
      bus_read(A_CFG);
      check("R5", "cfg readback", rdata, 8'hFF);
      bus_write(A_CFG, 8'h40);
      check("R5", "alt phase only", {6'b0, sdly, altph}, 8'h01);
      bus_write(A_CFG, 8'h00);
      bus_write(A_DATA, 8'h02);
      check("R6", "pin1 no pull-up", pu & 8'h02, 8'h00);
      bus_read(A_DATA);
      check("R6", "pin1 data stored", rdata, 8'h02);
   endtask

   task automatic t_pin_read(input logic [7:0] v);
      @(negedge clk);
      pad_in = v;
      @(negedge clk);
      bus_read(A_PIN);
      check("R7", "pin read", rdata, v);
      check("R8", "narrow pin read", rdata_n, v | 8'h0F);
      pad_in = ~v;
      @(negedge clk);
      check("R7", "rdata holds", rdata, v);
   endtask

   task automatic t_unmapped();
      bus_write(A_DATA, 8'h21);
      bus_write(8'h10, 8'h1C);
      bus_write(8'hD7, 8'h1C);
      bus_read(A_DATA);
      check("R9", "data unchanged", rdata, 8'h21);
      bus_read(A_CFG);
      check("R9", "cfg unchanged", rdata, 8'h00);
      bus_read(8'h10);
      check("R9", "unmapped read", rdata, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_encoding(8'h18, 8'h34);
      t_encoding(8'hFF, 8'hFF);
      t_encoding(8'h00, 8'h3D);
      t_strobes();
      t_mode_and_wdog();
      t_pin_read(8'hA5);
      t_pin_read(8'h5A);
      t_unmapped();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule